// File: doc/BRIEF.md
# Sync-Tagged Pixel Input Port

This block takes an external pixel stream that cannot be stalled. Each active beat carries four pixels and up to four sync pulses: vertical start, vertical end, horizontal start and horizontal end. The block turns each beat into one pipeline word. The word holds a frame-position tag, a 5-bit channel number taken from configuration, and the four pixels unchanged. There is no count of valid pixels, so every beat counts as four pixels. Padding at the end of a short line passes through like any other data.

Downstream consumes words with a valid/ready handshake. While it holds ready low, beats collect in an eight-entry buffer. When the buffer is full, an arriving beat is discarded and a one-cycle overflow interrupt is raised. The next beat that is actually stored is then tagged frame-start, whatever its syncs say. This makes a downstream address generator rewind to the start of its buffer instead of writing past the end.

Tags always follow the sync pulses of the current beat, and missing end pulses are never made up. After a corrupted stream, the next beat with a vertical-start pulse restores correct framing.

A small control state machine holds the overflow history:
- `ST_OFF`: the port is disabled.
- `ST_RUN`: normal tagging.
- `ST_FORCE`: a discard has happened and the next stored beat must carry the frame-start tag.

Its transitions are:
- Any state goes to `ST_OFF` when the enable is low.
- `ST_OFF` goes to `ST_RUN` when the enable is high and nothing is discarded.
- `ST_OFF` or `ST_RUN` goes to `ST_FORCE` on a discard.
- `ST_FORCE` goes to `ST_RUN` once a beat is written into the buffer.
- Otherwise the state holds.

Top module: `sync_tag_port`

## Requirements
- R1: While `cfg_en` is 0, input beats are not stored, regardless of their syncs. Any pending forced frame-start is cleared, so the first plain beat after re-enabling is tagged data (0). Words already buffered still drain.
- R2: Tag encoding is 3 bits: data=0, frame-start=1, line-start=2, line-end=3, frame-end=4. Precedence is vertical-start, then horizontal-start, then vertical-end, then horizontal-end, then data. A start pulse therefore beats any end pulse.
- R3: Each word carries the `cfg_chan` value present in the cycle its beat was accepted.
- R4: The 4×`PIX_W` pixel bits of an accepted beat appear unchanged on `out_pix`. Each active beat yields exactly one word, padding included.
- R5: Accepted beats go into a FIFO of `DEPTH` (8) entries. Order is preserved. A beat accepted into an empty buffer appears on the output in the next cycle.
- R6: A beat with `cfg_en`=1 and `in_valid`=1 is discarded when the buffer holds `DEPTH` words at that edge, even if a pop occurs at the same edge. `ovr_irq` is high for exactly the cycle after each discarded beat.
- R7: After a discard, the next beat written into the buffer is tagged frame-start (1), even without a vertical-start pulse. Later beats tag normally.
- R8: Beats that follow a missing line-end or frame-end are tagged by their own syncs, so plain beats stay data (0). The next beat with vertical-start is tagged frame-start.
- R9: While `out_valid`=1 and `out_ready`=0, the output word is held stable. A word is removed only at an edge where `out_ready`=1.
- R10: After reset, `out_valid` and `ovr_irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Port enable |
| cfg_chan | input | 5 | Channel number attached to each word |
| in_valid | input | 1 | Active beat qualifier |
| in_vs | input | 1 | Vertical start pulse |
| in_ve | input | 1 | Vertical end pulse |
| in_hs | input | 1 | Horizontal start pulse |
| in_he | input | 1 | Horizontal end pulse |
| in_pix | input | 4*PIX_W | Four pixels of the beat |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_tag | output | 3 | Frame-position tag |
| out_chan | output | 5 | Channel number of the word |
| out_pix | output | 4*PIX_W | Pixels of the word |
| ovr_irq | output | 1 | Overflow interrupt pulse |

## Verification
Suppose the control machine is stuck in the forced state or fails to enter it. The error shows on `out_tag` of the first word written after the next discard. That word reaches the port no later than the buffer takes to drain, and in the cycle after the write when the buffer is empty.

A wrong FIFO count or pointer shows within one cycle. It appears as a wrong `out_valid`, as out-of-order pixels, or as `ovr_irq` firing one beat early or late during a back-pressure burst.

Because words are compared on every clock against a queue model, any lost, duplicated or retagged beat is flagged at the first cycle it would be presented.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int TAG_W  = 3;
    localparam int CHAN_W = 5;
    localparam int LANES  = 4;

    typedef enum logic [TAG_W-1:0] {
        TAG_DATA = 3'd0,
        TAG_FS   = 3'd1,
        TAG_LS   = 3'd2,
        TAG_LE   = 3'd3,
        TAG_FE   = 3'd4
    } stp_tag_e;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FORCE = 2'd2
    } stp_state_e;

endpackage

// File: rtl/stp_tag_decode.sv
module stp_tag_decode
    import stp_pkg::*;
(
    input  logic     vs,
    input  logic     ve,
    input  logic     hs,
    input  logic     he,
    input  logic     force_fs,
    output stp_tag_e tag
);

    always_comb begin
        if (force_fs || vs) begin
            tag = TAG_FS;
        end else if (hs) begin
            tag = TAG_LS;
        end else if (ve) begin
            tag = TAG_FE;
        end else if (he) begin
            tag = TAG_LE;
        end else begin
            tag = TAG_DATA;
        end
    end

endmodule

// File: rtl/stp_ctrl.sv
module stp_ctrl
    import stp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       beat_valid,
    input  logic       buf_full,
    output logic       wr_en,
    output logic       drop,
    output logic       force_fs,
    output logic       ovr_irq,
    output stp_state_e state
);

    stp_state_e state_nxt;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= state_nxt;
        end
    end

    // Next-state logic
    always_comb begin
        state_nxt = state;
        if (!en) begin
            state_nxt = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nxt = drop  ? ST_FORCE : ST_RUN;
                ST_RUN:   state_nxt = drop  ? ST_FORCE : ST_RUN;
                ST_FORCE: state_nxt = wr_en ? ST_RUN   : ST_FORCE;
                default:  state_nxt = ST_OFF;
            endcase
        end
    end

    // Outputs
    always_comb begin
        wr_en    = 1'b0;
        drop     = 1'b0;
        force_fs = 1'b0;
        unique case (state)
            ST_OFF, ST_RUN: begin
                wr_en = en && beat_valid && !buf_full;
                drop  = en && beat_valid &&  buf_full;
            end
            ST_FORCE: begin
                wr_en    = en && beat_valid && !buf_full;
                drop     = en && beat_valid &&  buf_full;
                force_fs = 1'b1;
            end
            default: begin
                wr_en = 1'b0;
                drop  = 1'b0;
            end
        endcase
    end

    // Interrupt pulse, one cycle per discarded beat
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_irq <= 1'b0;
        end else begin
            ovr_irq <= drop;
        end
    end

endmodule

// File: rtl/stp_fifo.sv
module stp_fifo #(
    parameter int WIDTH = 40,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST    = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CT);
    assign rd_data = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_en) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/sync_tag_port.sv
module sync_tag_port
    import stp_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DEPTH = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_en,
    input  logic [CHAN_W-1:0]      cfg_chan,
    input  logic                   in_valid,
    input  logic                   in_vs,
    input  logic                   in_ve,
    input  logic                   in_hs,
    input  logic                   in_he,
    input  logic [LANES*PIX_W-1:0] in_pix,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [TAG_W-1:0]       out_tag,
    output logic [CHAN_W-1:0]      out_chan,
    output logic [LANES*PIX_W-1:0] out_pix,
    output logic                   ovr_irq
);

    localparam int PIXB   = LANES * PIX_W;
    localparam int WORD_W = TAG_W + CHAN_W + PIXB;
    localparam int CW     = $clog2(DEPTH + 1);

    stp_tag_e         beat_tag;
    stp_state_e       ctl_state;
    logic             buf_wr;
    logic             buf_rd;
    logic             buf_full;
    logic             buf_empty;
    logic             drop;
    logic             force_fs;
    logic [CW-1:0]    buf_count;
    logic [WORD_W-1:0] wr_word;
    logic [WORD_W-1:0] rd_word;

    stp_tag_decode u_dec (
        .vs       (in_vs),
        .ve       (in_ve),
        .hs       (in_hs),
        .he       (in_he),
        .force_fs (force_fs),
        .tag      (beat_tag)
    );

    stp_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .beat_valid (in_valid),
        .buf_full   (buf_full),
        .wr_en      (buf_wr),
        .drop       (drop),
        .force_fs   (force_fs),
        .ovr_irq    (ovr_irq),
        .state      (ctl_state)
    );

    assign wr_word = {beat_tag, cfg_chan, in_pix};
    assign buf_rd  = out_ready && !buf_empty;

    stp_fifo #(
        .WIDTH (WORD_W),
        .DEPTH (DEPTH)
    ) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (buf_wr),
        .wr_data (wr_word),
        .rd_en   (buf_rd),
        .rd_data (rd_word),
        .empty   (buf_empty),
        .full    (buf_full),
        .count   (buf_count)
    );

    assign out_valid = !buf_empty;
    assign out_tag   = rd_word[WORD_W-1 -: TAG_W];
    assign out_chan  = rd_word[PIXB +: CHAN_W];
    assign out_pix   = rd_word[PIXB-1:0];

endmodule

// File: rtl/sync_tag_port_chk.sv
module sync_tag_port_chk
    import stp_pkg::*;
#(
    parameter int PIX_W = 8,
    parameter int DEPTH = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cfg_en,
    input logic                       in_valid,
    input logic                       in_vs,
    input logic                       out_valid,
    input logic                       out_ready,
    input logic [TAG_W-1:0]           out_tag,
    input logic [CHAN_W-1:0]          out_chan,
    input logic [LANES*PIX_W-1:0]     out_pix,
    input logic                       ovr_irq,
    input logic                       wr_en,
    input logic                       force_fs,
    input logic [TAG_W-1:0]           wr_tag,
    input logic [$clog2(DEPTH+1)-1:0] fifo_count
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CT = CW'(DEPTH);

    // R1: nothing is written while disabled
    assert_disabled_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |-> !wr_en);

    // R2: vertical start wins
    assert_vs_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && in_vs) |-> (wr_tag == TAG_FS));

    // R5: occupancy bound
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= FULL_CT);

    // R6: interrupt only after a discard
    assert_irq_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_irq |-> $past(cfg_en && in_valid && (fifo_count == FULL_CT)));

    // R6: every discard raises the interrupt
    assert_irq_on_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && in_valid && (fifo_count == FULL_CT)) |=> ovr_irq);

    // R7: forced frame-start
    assert_forced_fs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && force_fs) |-> (wr_tag == TAG_FS));

    // R9: output held under back-pressure
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_tag) && $stable(out_chan) && $stable(out_pix)));

endmodule

bind sync_tag_port sync_tag_port_chk #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_en     (cfg_en),
    .in_valid   (in_valid),
    .in_vs      (in_vs),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_tag    (out_tag),
    .out_chan   (out_chan),
    .out_pix    (out_pix),
    .ovr_irq    (ovr_irq),
    .wr_en      (buf_wr),
    .force_fs   (force_fs),
    .wr_tag     (beat_tag),
    .fifo_count (buf_count)
);

// File: tb/sync_tag_port_tb.sv
module sync_tag_port_tb;

    localparam int PIX_W = 8;
    localparam int DEPTH = 8;
    localparam int PB    = 4 * PIX_W;
    localparam int WW    = 3 + 5 + PB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [4:0]    cfg_chan = 5'd0;
    logic          in_valid = 1'b0;
    logic          in_vs = 1'b0, in_ve = 1'b0, in_hs = 1'b0, in_he = 1'b0;
    logic [PB-1:0] in_pix = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [2:0]    out_tag;
    logic [4:0]    out_chan;
    logic [PB-1:0] out_pix;
    logic          ovr_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sync_tag_port #(.PIX_W(PIX_W), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_chan(cfg_chan),
        .in_valid(in_valid), .in_vs(in_vs), .in_ve(in_ve), .in_hs(in_hs),
        .in_he(in_he), .in_pix(in_pix), .out_valid(out_valid),
        .out_ready(out_ready), .out_tag(out_tag), .out_chan(out_chan),
        .out_pix(out_pix), .ovr_irq(ovr_irq)
    );

    // ---------------- reference model ----------------
    logic [WW-1:0] mq[$];
    bit            m_force = 1'b0;
    bit            m_irq   = 1'b0;

    function automatic logic [2:0] exp_tag(bit f, bit vs, bit ve, bit hs, bit he);
        if (f || vs) return 3'd1;
        if (hs)      return 3'd2;
        if (ve)      return 3'd4;
        if (he)      return 3'd3;
        return 3'd0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_force = 1'b0;
            m_irq   = 1'b0;
        end else begin
            bit pop, isfull, acc, dsc;
            pop    = out_ready && (mq.size() > 0);
            isfull = (mq.size() == DEPTH);
            acc    = cfg_en && in_valid && !isfull;
            dsc    = cfg_en && in_valid && isfull;
            if (pop) void'(mq.pop_front());
            if (acc) mq.push_back({exp_tag(m_force, in_vs, in_ve, in_hs, in_he), cfg_chan, in_pix});
            if (!cfg_en)  m_force = 1'b0;
            else if (dsc) m_force = 1'b1;
            else if (acc) m_force = 1'b0;
            m_irq = dsc;
        end
    end

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R5 out_valid", out_valid, mq.size() > 0);
            chk("R6 ovr_irq", ovr_irq, m_irq);
            if (mq.size() > 0 && out_valid) begin
                chk("R2 tag", out_tag, mq[0][WW-1 -: 3]);
                chk("R3 chan", out_chan, mq[0][PB +: 5]);
                chk("R4 pix", out_pix, mq[0][PB-1:0]);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(bit vs, bit ve, bit hs, bit he, logic [PB-1:0] p);
        in_valid = 1'b1; in_vs = vs; in_ve = ve; in_hs = hs; in_he = he; in_pix = p;
        @(negedge clk);
        in_valid = 1'b0; in_vs = 1'b0; in_ve = 1'b0; in_hs = 1'b0; in_he = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int irqs;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 out_valid", out_valid, 0);
        chk("R10 ovr_irq", ovr_irq, 0);

        // R2/R3/R4: tag precedence with an empty buffer and ready high
        cfg_en = 1'b1; cfg_chan = 5'h0A; out_ready = 1'b1;
        send(1, 0, 1, 0, 32'h11223344);
        chk("R2 vs+hs", out_tag, 1); chk("R3 chan", out_chan, 5'h0A); chk("R4 pix", out_pix, 32'h11223344);
        send(0, 0, 0, 0, 32'hA0A0A0A0); chk("R2 plain", out_tag, 0);
        send(0, 0, 0, 1, 32'h00000001); chk("R2 he", out_tag, 3);
        send(0, 1, 0, 1, 32'h00000002); chk("R2 ve+he", out_tag, 4);
        send(0, 1, 1, 0, 32'h00000003); chk("R2 hs+ve", out_tag, 2);
        send(1, 1, 1, 1, 32'h00000004); chk("R2 all", out_tag, 1);
        idle(2);

        // R5/R6: 12 beats into a stalled buffer, 4 discarded
        out_ready = 1'b0; irqs = 0;
        for (int i = 0; i < 12; i++) begin
            send(0, 0, 0, 0, 32'h100 + i);
            if (ovr_irq) irqs++;
        end
        @(negedge clk);
        chk("R6 irq count", irqs, 4);
        chk("R6 irq pulse ends", ovr_irq, 0);
        chk("R5 order", out_pix, 32'h100);
        out_ready = 1'b1;
        idle(10);
        // R7: first stored beat after discard is frame-start
        send(0, 0, 0, 0, 32'hF0F0); chk("R7 forced fs", out_tag, 1);
        send(0, 0, 0, 0, 32'hF0F1); chk("R7 after forced", out_tag, 0);
        idle(2);

        // R9: hold under back-pressure
        out_ready = 1'b0;
        send(0, 0, 0, 0, 32'hBEEF0001);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 hold pix", out_pix, 32'hBEEF0001);
            chk("R9 hold valid", out_valid, 1);
        end
        out_ready = 1'b1;
        idle(2);

        // R1: disabled input ignored
        cfg_en = 1'b0;
        send(1, 0, 1, 0, 32'hDEAD);
        chk("R1 disabled", out_valid, 0);
        idle(1);
        chk("R1 disabled later", out_valid, 0);
        // R1: disable clears pending forced frame-start
        cfg_en = 1'b1; out_ready = 1'b0;
        for (int i = 0; i < 9; i++) send(0, 0, 0, 0, 32'h200 + i);
        cfg_en = 1'b0; out_ready = 1'b1;
        idle(12);
        cfg_en = 1'b1;
        send(0, 0, 0, 0, 32'h300); chk("R1 force cleared", out_tag, 0);
        idle(2);

        // R8: missing ends, recovery on next frame start
        send(1, 0, 1, 0, 32'h400);
        send(0, 0, 0, 0, 32'h401);
        send(0, 0, 1, 0, 32'h402); chk("R8 line start", out_tag, 2);
        send(0, 0, 0, 0, 32'h403); chk("R8 data after missing end", out_tag, 0);
        send(0, 0, 0, 0, 32'h404); chk("R8 data", out_tag, 0);
        send(1, 0, 0, 0, 32'h405); chk("R8 resync fs", out_tag, 1);
        idle(2);

        // R3: channel captured at acceptance
        out_ready = 1'b0;
        cfg_chan = 5'd3; send(0, 0, 0, 0, 32'h500);
        cfg_chan = 5'd7; send(0, 0, 0, 0, 32'h501);
        cfg_chan = 5'd1;
        out_ready = 1'b1;
        chk("R3 first chan", out_chan, 3);
        @(negedge clk);
        chk("R3 second chan", out_chan, 7);
        idle(2);

        // random traffic, compared every clock by the model
        for (int i = 0; i < 4000; i++) begin
            cfg_en    = ($urandom_range(0, 19) != 0);
            out_ready = ($urandom_range(0, 2) != 0);
            if ($urandom_range(0, 15) == 0) cfg_chan = 5'($urandom);
            in_valid = ($urandom_range(0, 3) != 0);
            in_vs = ($urandom_range(0, 9) == 0);
            in_ve = ($urandom_range(0, 9) == 0);
            in_hs = ($urandom_range(0, 5) == 0);
            in_he = ($urandom_range(0, 5) == 0);
            in_pix = PB'($urandom);
            @(negedge clk);
        end
        in_valid = 1'b0; out_ready = 1'b1; cfg_en = 1'b1;
        idle(12);
        chk("R5 drained", out_valid, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule